// File: doc/BRIEF.md
# Descriptor-Chained DMA Engine

This block copies data between memory regions under the control of descriptors held in the same memory. Software starts it by presenting a descriptor pointer on the trigger pins. The engine reads the six-word descriptor, then moves the data one unit at a time. Each unit is one read followed by one write, and the engine has a single memory port that carries both descriptor fetches and data traffic.

Each descriptor has an inner count and an outer count. When an inner pass finishes with outer passes still left, the address words can be restored from two spare words in the descriptor. When the last pass is done, the engine either fetches the descriptor that lies directly after the current one in memory, or ends the chain and optionally raises an interrupt flag. Descriptors are never written back.

A descriptor is six 32-bit words at consecutive word addresses:
- word 0: control word
- word 1: counts
- word 2: source address
- word 3: destination address
- word 4: spare source address
- word 5: spare destination address

On the memory port, a request is transferred in a cycle where `mem_req_valid` and `mem_req_ready` are both high. While `mem_req_valid` is high and `mem_req_ready` is low, the engine holds the request and all of its fields unchanged. The memory may stall by keeping `mem_req_ready` low. A read is answered by a single-cycle `mem_rsp_valid` pulse, which the engine always accepts; there is no response back-pressure. Read data sits little-endian in the low lanes of `mem_rsp_data`, and write data is placed the same way.

Top module: `desc_chain_dma`

## Requirements
- R1: When the engine is idle, a cycle with `trig_valid` high starts it. It reads words 0..5 from `trig_ptr`, `trig_ptr+4`, ... `trig_ptr+20` as 32-bit reads. `busy` is high from the cycle after the trigger, and `irq` is cleared by the trigger.
- R2: Control word fields: bit 21 is chain-next, bit 20 is raise-interrupt, bits [15:13] are destination address mode, bits [12:10] are source address mode, bits [9:8] are unit width, and bits [7:5] are the reload selection. All other bits are ignored. Word 1 holds the outer count in [31:16] and the inner count in [15:0], and both are nonzero.
- R3: One descriptor moves inner times outer units, each a read then a write. Width code 00 gives 1 byte, 01 gives 2 bytes and 10 gives 4 bytes, and the code is presented on `mem_req_size` for data accesses.
- R4: When the top bit of an address mode field (bit 15 or bit 12) is 1, that address advances by the unit size after each unit. When it is 0, the address stays fixed.
- R5: After each inner pass except the last, the inner count restarts. If bit 7 is set, the source address is taken from word 4; if bit 6 is set, the destination address is taken from word 5. Otherwise each address continues.
- R6: With chain-next set, finishing a descriptor fetches and runs the descriptor at its pointer plus 24, and no interrupt is raised.
- R7: With chain-next clear, `busy` falls when the descriptor finishes. `irq` rises in that same cycle if raise-interrupt is set and otherwise stays low. `irq` holds until the next trigger.
- R8: A trigger while `busy` is high is ignored.
- R9: The engine never writes any descriptor word.
- R10: A request held while `mem_req_ready` is low keeps all of its fields stable. At most one read is outstanding at a time. No request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Software start strobe |
| trig_ptr | input | AW | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Transfer-done interrupt flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_size | output | 2 | 00 byte, 01 half, 10 word |
| mem_req_wdata | output | DW | Write data, low lanes |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | DW | Read data, low lanes |

## Verification
The end of the last inner pass can coincide with the end of the descriptor. In that case the outer reload and the chain-or-finish decision are taken from the same state. The bench provokes this with a half-word descriptor that runs two outer passes with source reload and then chains into a fixed-source byte descriptor, while the memory stalls at random. The result is judged by checking three things: the destination holds exactly two copies of the reloaded source, the chained descriptor's output appears, and the interrupt comes only from the second descriptor. A trigger pulsed in the middle of that run must leave its own target region untouched.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int DESC_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_RELOAD, ST_CHAIN, ST_DONE
  } dma_state_e;

  typedef struct packed {
    logic       chain_go;
    logic       irq_req;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] width;
    logic       rl_src;
    logic       rl_dst;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [31:0] w);
    ctl_t c;
    c.chain_go = w[21];
    c.irq_req  = w[20];
    c.dst_inc  = w[15];
    c.src_inc  = w[12];
    c.width    = w[9:8];
    c.rl_src   = w[7];
    c.rl_dst   = w[6];
    return c;
  endfunction

  function automatic logic [2:0] unit_bytes(input logic [1:0] width);
    case (width)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import desc_dma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output ctl_t             ctl,
  output logic [CNT_W-1:0] inner_init,
  output logic [CNT_W-1:0] outer_init,
  output logic [DW-1:0]    src_init,
  output logic [DW-1:0]    dst_init,
  output logic [DW-1:0]    src_spare,
  output logic [DW-1:0]    dst_spare
);
  logic [DW-1:0] words [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        words[g] <= wr_data;
    end
  end

  assign ctl        = decode_ctl(words[0]);
  assign inner_init = words[1][CNT_W-1:0];
  assign outer_init = words[1][DW/2 +: CNT_W];
  assign src_init   = words[2];
  assign dst_init   = words[3];
  assign src_spare  = words[4];
  assign dst_spare  = words[5];
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             pass_next,
  input  logic [CNT_W-1:0] inner_init,
  input  logic [CNT_W-1:0] outer_init,
  output logic             inner_last,
  output logic             outer_last
);
  logic [CNT_W-1:0] inner_q, outer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (load) begin
      inner_q <= inner_init;
      outer_q <= outer_init;
    end else if (pass_next) begin
      inner_q <= inner_init;
      outer_q <= outer_q - 1'b1;
    end else if (step) begin
      inner_q <= inner_q - 1'b1;
    end
  end

  assign inner_last = (inner_q == CNT_W'(1));
  assign outer_last = (outer_q == CNT_W'(1));
endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          reload,
  input  logic          reload_en,
  input  logic [AW-1:0] reload_val,
  input  logic          step,
  input  logic          inc_en,
  input  logic [2:0]    stride,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= load_val;
    else if (reload && reload_en)
      addr <= reload_val;
    else if (step && inc_en)
      addr <= addr + AW'(stride);
  end
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import desc_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_valid,
  input  logic [AW-1:0] trig_ptr,
  output logic          busy,
  output logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_size,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int WORD_BYTES = DW / 8;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
  localparam int IDX_W      = $clog2(DESC_WORDS + 1);

  dma_state_e       state_q;
  logic [AW-1:0]    ptr_q;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q;
  logic [DW-1:0]    data_q;
  logic             irq_q;

  ctl_t             ctl;
  logic [CNT_W-1:0] inner_init, outer_init;
  logic [DW-1:0]    src_init, dst_init, src_spare, dst_spare;
  logic [AW-1:0]    src_addr, dst_addr;
  logic             inner_last, outer_last;

  logic req_fire, rsp_hit, fetch_done, desc_wr, load, step, pass_next, reload;
  logic [2:0] stride;

  assign req_fire   = mem_req_valid && mem_req_ready;
  assign rsp_hit    = mem_rsp_valid && pend_q;
  assign fetch_done = (state_q == ST_FETCH) && (idx_q == IDX_W'(DESC_WORDS));
  assign desc_wr    = (state_q == ST_FETCH) && rsp_hit;
  assign load       = fetch_done;
  assign step       = (state_q == ST_WRITE) && req_fire;
  assign reload     = (state_q == ST_RELOAD) && !outer_last;
  assign pass_next  = reload;
  assign stride     = unit_bytes(ctl.width);

  dma_desc_regs #(.DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(desc_wr), .wr_idx(idx_q), .wr_data(mem_rsp_data),
    .ctl(ctl), .inner_init(inner_init), .outer_init(outer_init),
    .src_init(src_init), .dst_init(dst_init),
    .src_spare(src_spare), .dst_spare(dst_spare)
  );

  dma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(load), .step(step), .pass_next(pass_next),
    .inner_init(inner_init), .outer_init(outer_init),
    .inner_last(inner_last), .outer_last(outer_last)
  );

  dma_addr_ptr #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(AW'(src_init)),
    .reload(reload), .reload_en(ctl.rl_src), .reload_val(AW'(src_spare)),
    .step(step), .inc_en(ctl.src_inc), .stride(stride),
    .addr(src_addr)
  );

  dma_addr_ptr #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(AW'(dst_init)),
    .reload(reload), .reload_en(ctl.rl_dst), .reload_val(AW'(dst_spare)),
    .step(step), .inc_en(ctl.dst_inc), .stride(stride),
    .addr(dst_addr)
  );

  // Memory request port
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_size  = 2'b10;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_valid = !pend_q && (idx_q < IDX_W'(DESC_WORDS));
        mem_req_addr  = ptr_q + AW'(idx_q * WORD_BYTES);
      end
      ST_READ: begin
        mem_req_valid = !pend_q;
        mem_req_addr  = src_addr;
        mem_req_size  = ctl.width;
      end
      ST_WRITE: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_addr;
        mem_req_size  = ctl.width;
      end
      default: ;
    endcase
  end
  assign mem_req_wdata = data_q;

  // Outstanding-read tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (req_fire && !mem_req_write)
      pend_q <= 1'b1;
    else if (mem_rsp_valid)
      pend_q <= 1'b0;
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_valid) begin
          ptr_q   <= trig_ptr;
          idx_q   <= '0;
          irq_q   <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (fetch_done)
            state_q <= ST_READ;
          else if (rsp_hit)
            idx_q <= idx_q + 1'b1;
        end
        ST_READ: if (rsp_hit) begin
          data_q  <= mem_rsp_data;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (req_fire)
          state_q <= inner_last ? ST_RELOAD : ST_READ;
        ST_RELOAD: begin
          if (!outer_last)
            state_q <= ST_READ;
          else
            state_q <= ctl.chain_go ? ST_CHAIN : ST_DONE;
        end
        ST_CHAIN: begin
          ptr_q   <= ptr_q + AW'(DESC_BYTES);
          idx_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_DONE: begin
          irq_q   <= ctl.irq_req;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign irq  = irq_q;
endmodule

// File: rtl/desc_chain_dma_chk.sv
module desc_chain_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          irq,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid
);
  logic rd_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write)
      rd_open <= 1'b1;
    else if (mem_rsp_valid)
      rd_open <= 1'b0;
  end

  // R10
  held_req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_size) && $stable(mem_req_wdata));

  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rd_open);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R7
  irq_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
endmodule

bind desc_chain_dma desc_chain_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/desc_chain_dma_tb.sv
`timescale 1ns/1ps
module desc_chain_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic [31:0] trig_ptr = '0;
  logic        busy, irq;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  logic stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];

  always #2.5 clk = ~clk;

  desc_chain_dma u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ptr(trig_ptr),
    .busy(busy), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Memory model: optional random stalls, one-cycle read latency
  always @(posedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:0]] = mem_req_wdata[7:0];
        if (mem_req_size != 2'b00) mem[mem_req_addr[9:0] + 10'd1] = mem_req_wdata[15:8];
        if (mem_req_size == 2'b10) begin
          mem[mem_req_addr[9:0] + 10'd2] = mem_req_wdata[23:16];
          mem[mem_req_addr[9:0] + 10'd3] = mem_req_wdata[31:24];
        end
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {mem[mem_req_addr[9:0] + 10'd3], mem[mem_req_addr[9:0] + 10'd2],
                          mem[mem_req_addr[9:0] + 10'd1], mem[mem_req_addr[9:0]]};
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = (i < 256) ? 8'(i * 7 + 3) : 8'h00;
      exp_mem[i] = mem[i];
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[a + b]     = w[8*b +: 8];
      exp_mem[a + b] = w[8*b +: 8];
    end
  endtask

  // Writes a descriptor and applies its effect to the expected image
  task automatic add_desc(input int base, input logic [31:0] ctl, input int inner, input int outer,
                          input int src, input int dst, input int sp_src, input int sp_dst);
    int ub, s, d;
    put_word(base,      ctl);
    put_word(base + 4,  {16'(outer), 16'(inner)});
    put_word(base + 8,  32'(src));
    put_word(base + 12, 32'(dst));
    put_word(base + 16, 32'(sp_src));
    put_word(base + 20, 32'(sp_dst));
    ub = (ctl[9:8] == 2'b00) ? 1 : (ctl[9:8] == 2'b01) ? 2 : 4;
    s = src; d = dst;
    for (int o = 0; o < outer; o++) begin
      for (int i = 0; i < inner; i++) begin
        for (int b = 0; b < ub; b++) exp_mem[d + b] = exp_mem[s + b];
        if (ctl[12]) s += ub;
        if (ctl[15]) d += ub;
      end
      if (o < outer - 1) begin
        if (ctl[7]) s = sp_src;
        if (ctl[6]) d = sp_dst;
      end
    end
  endtask

  task automatic cmp_region(input string tag, input int lo, input int hi);
    int bad = 0;
    for (int i = lo; i <= hi; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic start(input int ptr);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_ptr   = 32'(ptr);
    @(negedge clk);
    trig_valid = 1'b0;
    chk("R1 busy after trigger", {31'd0, busy}, 32'd1);
    chk("R1 irq cleared by trigger", {31'd0, irq}, 32'd0);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 40000 && busy; n++) @(negedge clk);
  endtask

  localparam logic [15:0] VEC_SRC [4] = '{16'h000, 16'h040, 16'h080, 16'h0C0};
  localparam logic [15:0] VEC_DST [4] = '{16'h1C0, 16'h100, 16'h180, 16'h140};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R7 reset irq", {31'd0, irq}, 32'd0);
    chk("R10 reset request", {31'd0, mem_req_valid}, 32'd0);

    // Four-descriptor chain rearranging 256 bytes (R2, R3, R6)
    for (int k = 0; k < 4; k++)
      add_desc(32'h200 + k * 24, (k < 3) ? 32'h702090C3 : 32'h401090C3, 16'h40, 1,
               VEC_SRC[k], VEC_DST[k], VEC_SRC[k], VEC_DST[k]);
    start(32'h200);
    wait_idle();
    for (int k = 0; k < 4; k++)
      cmp_region((k == 0) ? "R2 first block" : "R6 chained block",
                 int'(VEC_DST[k]), int'(VEC_DST[k]) + 63);
    chk("R7 irq after chain", {31'd0, irq}, 32'd1);
    chk("R10 idle after chain", {31'd0, mem_req_valid}, 32'd0);
    cmp_region("R9 descriptors intact", 32'h200, 32'h25F);

    // Two outer passes with source reload, chained into fixed-source byte copy, with stalls
    init_mem();
    stall_en = 1'b1;
    add_desc(32'h300, 32'h00209180, 8, 2, 32'h020, 32'h100, 32'h020, 32'h3F0);
    add_desc(32'h318, 32'h00108000, 4, 1, 32'h0A5, 32'h140, 32'h000, 32'h000);
    put_word(32'h330, 32'h00009000);
    put_word(32'h334, {16'd1, 16'd16});
    put_word(32'h338, 32'h000);
    put_word(32'h33C, 32'h180);
    start(32'h300);
    repeat (20) @(negedge clk);
    trig_valid = 1'b1; trig_ptr = 32'h330;
    @(negedge clk);
    trig_valid = 1'b0;
    wait_idle();
    cmp_region("R5 outer reload", 32'h100, 32'h13F);
    cmp_region("R4 fixed source", 32'h140, 32'h147);
    cmp_region("R3 halfword units", 32'h100, 32'h11F);
    cmp_region("R8 ignored trigger", 32'h180, 32'h1BF);
    chk("R7 irq from last descriptor", {31'd0, irq}, 32'd1);
    cmp_region("R9 descriptors intact", 32'h300, 32'h35F);

    // Word units, chain and interrupt both clear
    stall_en = 1'b0;
    add_desc(32'h348, 32'h00009200, 3, 1, 32'h010, 32'h1E0, 0, 0);
    start(32'h348);
    wait_idle();
    cmp_region("R3 word units", 32'h1E0, 32'h1EF);
    chk("R7 no irq without flag", {31'd0, irq}, 32'd0);
    chk("R7 busy low at end", {31'd0, busy}, 32'd0);

    summary();
    $finish;
  end
endmodule